// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block models the device side of a synchronous DRAM column path. A controller issues READ or WRITE column commands carrying a bank, a starting column and a burst-length choice. The block stores write beats in a small internal array. It returns read beats on its data output a fixed CAS latency after the command, and each beat comes from the next column of an aligned, wrapping block.

The clock-enable input gates the internal clock edge. A low clock enable sampled at one rising edge cancels the following internal edge. On that cancelled edge the burst counters, the latency countdown and command capture all freeze, and the data output and its enable keep their values. The block is meant for controller test environments that need a cycle-exact, synthesizable memory partner able to exercise suspend.

Top module: `sdram_suspend_burst`

## Requirements
- R1: While reset is asserted and after it is released, `dq_oe` is 0 and no burst is in progress.
- R2: A WRITE (`cmd` = 2'b10) on an enabled edge stores `dq_in` at the start column, and `dq_in` on each of the next BL-1 enabled edges is stored at the following burst columns.
- R3: A READ (`cmd` = 2'b01) on an enabled edge puts the first beat on `dq_out` with `dq_oe` = 1 after the CAS-latency-th enabled edge that follows (latency 3 by default). The remaining beats follow on consecutive enabled edges, and `dq_oe` returns to 0 on the enabled edge after the last beat. The codes 2'b00 and 2'b11 are NOP.
- R4: `burst_long` = 1 selects a burst length of 4 and 0 selects 2. Beat i goes to column (start & ~(BL-1)) | ((start + i) & (BL-1)), so the burst wraps inside its aligned block.
- R5: A rising edge at which `cke` is sampled 0 makes the next rising edge a suspended edge. A rising edge is enabled exactly when `cke` was 1 at the rising edge before it.
- R6: A command and `dq_in` present at a suspended edge are ignored: nothing is stored and no burst starts.
- R7: Across a suspended edge, `dq_out` and `dq_oe` keep their values, so read data already on the bus stays driven.
- R8: Burst progress does not advance on a suspended edge. After resume, the burst continues with the next column and no beat is skipped or repeated.
- R9: Sampling `cke` = 1 ends the suspend, and the next rising edge is enabled again.
- R10: A WRITE on an enabled edge during a read burst ends the read, so `dq_oe` is 0 after that edge. The write data presented with the WRITE is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; a low value suspends the next internal edge |
| cmd | input | 2 | Column command: 01 READ, 10 WRITE, 00/11 NOP |
| bank | input | BANK_W | Bank select for the command |
| col | input | COL_W | Start column for the command |
| burst_long | input | 1 | 1: burst of 4, 0: burst of 2 |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | Read data valid / output drive enable |

## Verification
A wrong internal state in this block shows up at the data port within one burst. A latency counter that is off shifts the first `dq_oe` by a cycle. A burst counter that moves on a suspended edge skips or repeats a column, and the scoreboard sees that as wrong data on the very next enabled beat. A wrong wrap mask or a lost write beat appears when the block is read back, three edges after the READ. If a suspended edge were not gated, `dq_out` would change while the bench expects it to hold, and that mismatch is seen one cycle after `cke` goes low.

// File: rtl/sdram_sb_pkg.sv
package sdram_sb_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_NOP2  = 2'b11
    } col_cmd_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'b00,
        ENG_RD   = 2'b01,
        ENG_WR   = 2'b10
    } eng_mode_e;

endpackage

// File: rtl/sdram_sb_colgen.sv
module sdram_sb_colgen #(
    parameter int COL_W = 4,
    parameter int OFS_W = 2
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [OFS_W-1:0] beat_ofs,
    input  logic [COL_W-1:0] wrap_mask,
    output logic [COL_W-1:0] beat_col
);
    // Upper bits come from the start column; low bits count and wrap inside the aligned block
    always_comb begin
        beat_col = (base_col & ~wrap_mask) | ((base_col + COL_W'(beat_ofs)) & wrap_mask);
    end
endmodule

// File: rtl/sdram_sb_array.sv
module sdram_sb_array #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/sdram_suspend_burst.sv
module sdram_suspend_burst
    import sdram_sb_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int BANK_W  = 2,
    parameter int COL_W   = 4,
    parameter int CAS_LAT = 3,
    parameter int MAX_BL  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic              burst_long,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int OFS_W  = $clog2(MAX_BL);
    localparam int CNT_W  = OFS_W + 1;
    localparam int LAT_W  = $clog2(CAS_LAT + 1);
    localparam int ADDR_W = BANK_W + COL_W;

    typedef struct packed {
        logic              cke_q;
        eng_mode_e         mode;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [COL_W-1:0]  mask;
        logic [OFS_W-1:0]  ofs;
        logic [CNT_W-1:0]  left;
        logic [LAT_W-1:0]  wait_n;
        logic [DATA_W-1:0] dq;
        logic              oe;
    } eng_st_t;

    eng_st_t s_d, s_q;

    col_cmd_e          cmd_v;
    logic              edge_en;
    logic              new_wr, new_rd;
    logic [COL_W-1:0]  len_mask;
    logic [CNT_W-1:0]  len_beats;
    logic [COL_W-1:0]  burst_col;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_rdata;
    logic              arr_we;

    assign cmd_v     = col_cmd_e'(cmd);
    assign edge_en   = s_q.cke_q;
    assign new_wr    = edge_en && (cmd_v == CMD_WRITE);
    assign new_rd    = edge_en && (cmd_v == CMD_READ);
    assign len_mask  = burst_long ? COL_W'(MAX_BL - 1) : COL_W'(MAX_BL / 2 - 1);
    assign len_beats = burst_long ? CNT_W'(MAX_BL) : CNT_W'(MAX_BL / 2);
    assign arr_addr  = new_wr ? {bank, col} : {s_q.bank, burst_col};

    sdram_sb_colgen #(
        .COL_W (COL_W),
        .OFS_W (OFS_W)
    ) colgen_i (
        .base_col  (s_q.col),
        .beat_ofs  (s_q.ofs),
        .wrap_mask (s_q.mask),
        .beat_col  (burst_col)
    );

    sdram_sb_array #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) array_i (
        .clk   (clk),
        .we    (arr_we),
        .addr  (arr_addr),
        .wdata (dq_in),
        .rdata (arr_rdata)
    );

    always_comb begin
        s_d       = s_q;
        s_d.cke_q = cke;
        arr_we    = 1'b0;
        if (edge_en) begin
            if (new_wr) begin
                arr_we     = 1'b1;
                s_d.mode   = ENG_WR;
                s_d.bank   = bank;
                s_d.col    = col;
                s_d.mask   = len_mask;
                s_d.ofs    = OFS_W'(1);
                s_d.left   = len_beats - CNT_W'(1);
                s_d.wait_n = '0;
                s_d.oe     = 1'b0;
            end else if (new_rd) begin
                s_d.mode   = ENG_RD;
                s_d.bank   = bank;
                s_d.col    = col;
                s_d.mask   = len_mask;
                s_d.ofs    = '0;
                s_d.left   = len_beats;
                s_d.wait_n = LAT_W'(CAS_LAT - 1);
                s_d.oe     = 1'b0;
            end else begin
                unique case (s_q.mode)
                    ENG_WR: begin
                        if (s_q.left != '0) begin
                            arr_we   = 1'b1;
                            s_d.ofs  = s_q.ofs + OFS_W'(1);
                            s_d.left = s_q.left - CNT_W'(1);
                            if (s_q.left == CNT_W'(1)) begin
                                s_d.mode = ENG_IDLE;
                            end
                        end else begin
                            s_d.mode = ENG_IDLE;
                        end
                    end
                    ENG_RD: begin
                        if (s_q.wait_n != '0) begin
                            s_d.wait_n = s_q.wait_n - LAT_W'(1);
                        end else if (s_q.left != '0) begin
                            s_d.dq   = arr_rdata;
                            s_d.oe   = 1'b1;
                            s_d.ofs  = s_q.ofs + OFS_W'(1);
                            s_d.left = s_q.left - CNT_W'(1);
                        end else begin
                            s_d.oe   = 1'b0;
                            s_d.mode = ENG_IDLE;
                        end
                    end
                    default: begin
                        s_d.oe = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.cke_q <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dq_out = s_q.dq;
    assign dq_oe  = s_q.oe;

    initial begin
        if (CAS_LAT < 2 || MAX_BL < 2) begin
            $error("CAS_LAT must be at least 2 and MAX_BL at least 2");
        end
    end

    // R1: reset leaves the bus released
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !dq_oe);

    // R7: a suspended edge leaves the data bus untouched
    a_r7_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cke_q |=> $stable(dq_out) && $stable(dq_oe));

    // R8: burst progress is frozen on a suspended edge
    a_r8_progress_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cke_q |=> $stable(s_q.ofs) && $stable(s_q.left) && $stable(s_q.wait_n));

    // R3: an accepted READ never drives data on the next cycle
    a_r3_latency_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cke_q && cmd_v == CMD_READ) |=> !dq_oe);

    // R10: an accepted WRITE releases the bus
    a_r10_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cke_q && cmd_v == CMD_WRITE) |=> !dq_oe);
endmodule

// File: tb/sdram_suspend_burst_tb.sv
`timescale 1ns/1ps
module sdram_suspend_burst_tb_top;
    localparam int DATA_W  = 16;
    localparam int BANK_W  = 2;
    localparam int COL_W   = 4;
    localparam int CAS_LAT = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke = 1'b1;
    logic [1:0]        cmd = 2'b00;
    logic [BANK_W-1:0] bank = '0;
    logic [COL_W-1:0]  col = '0;
    logic              burst_long = 1'b0;
    logic [DATA_W-1:0] dq_in = '0;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] shadow [64];
    logic [DATA_W-1:0] exp_q [$];

    logic              cke_hist = 1'b1;
    logic              tb_en = 1'b1;
    logic [DATA_W-1:0] last_dq = '0;
    logic              last_oe = 1'b0;

    always #2 clk = ~clk;

    sdram_suspend_burst dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cmd        (cmd),
        .bank       (bank),
        .col        (col),
        .burst_long (burst_long),
        .dq_in      (dq_in),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    // R5: an edge is enabled when cke was high at the edge before it
    always @(posedge clk) begin
        tb_en    <= cke_hist;
        cke_hist <= cke;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [COL_W-1:0] wcol(input logic [COL_W-1:0] s, input int i, input int bl);
        logic [COL_W-1:0] m;
        m = COL_W'(bl - 1);
        return (s & ~m) | ((s + COL_W'(i)) & m);
    endfunction

    task automatic cyc(input logic [1:0] c, input int bk, input int cl, input bit b4,
                       input logic [DATA_W-1:0] d, input bit ck);
        @(negedge clk);
        cmd        = c;
        bank       = BANK_W'(bk);
        col        = COL_W'(cl);
        burst_long = b4;
        dq_in      = d;
        cke        = ck;
    endtask

    task automatic nop(input bit ck);
        cyc(2'b00, 0, 0, 1'b0, 16'h0, ck);
    endtask

    // R2 / R4: unsuspended write burst, shadow updated at wrapped columns
    task automatic wr_burst(input int bk, input int cl, input bit b4, input logic [DATA_W-1:0] base);
        int bl;
        bl = b4 ? 4 : 2;
        for (int i = 0; i < bl; i++) begin
            cyc(i == 0 ? 2'b10 : 2'b00, bk, cl, b4, base + DATA_W'(i), 1'b1);
            shadow[{BANK_W'(bk), wcol(COL_W'(cl), i, bl)}] = base + DATA_W'(i);
        end
        nop(1'b1);
    endtask

    // R3 / R4: read burst with latency and release checks
    task automatic rd_burst(input int bk, input int cl, input bit b4);
        int bl;
        bit exp_oe;
        bl = b4 ? 4 : 2;
        for (int i = 0; i < bl; i++) begin
            exp_q.push_back(shadow[{BANK_W'(bk), wcol(COL_W'(cl), i, bl)}]);
        end
        cyc(2'b01, bk, cl, b4, 16'h0, 1'b1);
        for (int k = 1; k <= CAS_LAT + bl + 1; k++) begin
            nop(1'b1);
            exp_oe = (k > CAS_LAT) && (k <= CAS_LAT + bl);
            check(dq_oe == exp_oe, "R3 read window", dq_oe, exp_oe);
        end
        check(exp_q.size() == 0, "R3 beat count", exp_q.size(), 0);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (dq_oe) begin
                if (tb_en) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3 unexpected beat", dq_out, 0);
                    end else begin
                        logic [DATA_W-1:0] e;
                        e = exp_q.pop_front();
                        check(dq_out == e, "R4/R8 beat data", dq_out, e);
                    end
                end else begin
                    check(last_oe && dq_out == last_dq, "R7 held on suspend", dq_out, last_dq);
                end
            end else if (!tb_en && last_oe) begin
                check(1'b0, "R7 bus dropped on suspend", 0, 1);
            end
            last_dq = dq_out;
            last_oe = dq_oe;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        check(dq_oe == 1'b0, "R1 oe in reset", dq_oe, 0);
        rst_n = 1'b1;
        nop(1'b1);
        nop(1'b1);
        check(dq_oe == 1'b0, "R1 oe after reset", dq_oe, 0);

        // R2 R4: BL4 write starting mid-block, then read it back
        wr_burst(1, 5, 1'b1, 16'h1100);
        rd_burst(1, 5, 1'b1);
        rd_burst(1, 4, 1'b1);

        // R4: BL2 wrap
        wr_burst(2, 3, 1'b0, 16'h2200);
        rd_burst(2, 3, 1'b0);
        rd_burst(2, 2, 1'b0);

        // R6 R8 R9: write burst with one suspended edge carrying junk data
        cyc(2'b10, 0, 8, 1'b1, 16'hA000, 1'b1);
        cyc(2'b00, 0, 0, 1'b1, 16'hA001, 1'b0);
        cyc(2'b00, 0, 0, 1'b1, 16'hDEAD, 1'b1);
        cyc(2'b00, 0, 0, 1'b1, 16'hA002, 1'b1);
        cyc(2'b00, 0, 0, 1'b1, 16'hA003, 1'b1);
        nop(1'b1);
        shadow[{2'd0, 4'd8}]  = 16'hA000;
        shadow[{2'd0, 4'd9}]  = 16'hA001;
        shadow[{2'd0, 4'd10}] = 16'hA002;
        shadow[{2'd0, 4'd11}] = 16'hA003;
        rd_burst(0, 8, 1'b1);

        // R6: a READ on a suspended edge starts nothing
        nop(1'b0);
        cyc(2'b01, 1, 5, 1'b1, 16'h0, 1'b1);
        for (int k = 0; k < 8; k++) begin
            nop(1'b1);
            check(dq_oe == 1'b0, "R6 suspended read ignored", dq_oe, 0);
        end

        // R7 R8 R9: suspend during latency and during the data phase
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back(shadow[{2'd1, wcol(4'd5, i, 4)}]);
        end
        hi = 0;
        cyc(2'b01, 1, 5, 1'b1, 16'h0, 1'b1);
        nop(1'b0); hi += int'(dq_oe);
        nop(1'b1); hi += int'(dq_oe);
        nop(1'b1); hi += int'(dq_oe);
        nop(1'b1); hi += int'(dq_oe);
        nop(1'b0); hi += int'(dq_oe);
        nop(1'b0); hi += int'(dq_oe);
        nop(1'b1); hi += int'(dq_oe);
        for (int k = 0; k < 8; k++) begin
            nop(1'b1);
            hi += int'(dq_oe);
        end
        check(hi == 6, "R8 oe cycles with suspend", hi, 6);
        check(exp_q.size() == 0, "R9 all beats after resume", exp_q.size(), 0);

        // R10: WRITE ends a read after its first beat
        exp_q.push_back(shadow[{2'd1, 4'd5}]);
        cyc(2'b01, 1, 5, 1'b1, 16'h0, 1'b1);
        nop(1'b1);
        nop(1'b1);
        nop(1'b1);
        cyc(2'b10, 3, 0, 1'b0, 16'hB000, 1'b1);
        cyc(2'b00, 0, 0, 1'b0, 16'hB001, 1'b1);
        check(dq_oe == 1'b0, "R10 bus released by write", dq_oe, 0);
        nop(1'b1);
        check(exp_q.size() == 0, "R10 one beat only", exp_q.size(), 0);
        shadow[{2'd3, 4'd0}] = 16'hB000;
        shadow[{2'd3, 4'd1}] = 16'hB001;
        rd_burst(3, 0, 1'b0);

        repeat (4) nop(1'b1);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule